// File: doc/BRIEF.md
# Link-Register-Hinted Return Address Stack

This block predicts return targets for an instruction-fetch front end. It sees one jump event per cycle. Each event says whether it is a direct jump-and-link or an indirect register jump. It also carries the destination register number, the source register number and the address of the following instruction. The block does not look at opcodes or targets. It infers each stack action from the two register numbers: nothing, a push of the return address, a pop that yields a predicted target, or a pop followed by a push in the same cycle for coroutine switches.

The storage is a circular stack of `DEPTH` entries. When the stack is full, a new push overwrites the oldest entry and raises no error. A pop on an empty stack yields no prediction and leaves the state alone. The prediction is combinational in the cycle the event is presented, and the stack updates at the following clock edge. A synchronous clear input empties the stack; the front end uses it when it flushes after a misprediction.

Top module: `ras_top`

## Requirements
- R1: A register number counts as a link register only when it is 1 or 5. Every other number, including 0, is treated as an ordinary register.
- R2: A direct jump event (`evIsJalr`=0) never produces a prediction. It pushes `evNextPc` only when its destination is a link register; otherwise the stack is untouched.
- R3: An indirect jump (`evIsJalr`=1) whose destination is a link register and whose source is not pushes `evNextPc` and produces no prediction.
- R4: An indirect jump whose source is a link register and whose destination is not pops the most recent entry. It drives that entry on `predTarget` with `predValid`=1 in the same cycle as the event.
- R5: An indirect jump in which neither register is a link register leaves the stack unchanged and produces no prediction.
- R6: An indirect jump whose destination and source are two different link registers predicts the most recent entry and replaces it with `evNextPc` in one cycle, so occupancy stays the same. On an empty stack it produces no prediction and behaves as a push.
- R7: An indirect jump whose destination and source are the same link register only pushes and produces no prediction.
- R8: A pop on an empty stack gives `predValid`=0, `predTarget`=0, and leaves the stack unchanged.
- R9: The stack holds `DEPTH` (default 8) entries. A push on a full stack discards the oldest entry, and the newest `DEPTH` entries remain available in last-in first-out order.
- R10: `clearReq` high at a clock edge leaves the stack empty after that edge. It takes priority over an event in the same cycle, and that event produces no prediction.
- R11: `stackEmpty` is 1 exactly when no entries are held, including straight after reset. `predTarget` is 0 whenever `predValid` is 0.
- R12: With `evValid`=0 the stack is unchanged and no prediction is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clearReq | input | 1 | Synchronous flush of all entries |
| evValid | input | 1 | A jump event is present this cycle |
| evIsJalr | input | 1 | 1 = indirect register jump, 0 = direct jump |
| evRd | input | 5 | Destination register number |
| evRs1 | input | 5 | Source register number (ignored for direct jumps) |
| evNextPc | input | ADDR_W | Address of the instruction after the jump |
| predValid | output | 1 | A predicted return target is being supplied |
| predTarget | output | ADDR_W | Predicted return target, 0 when not valid |
| stackEmpty | output | 1 | No entries held |

## Verification
The assertions assume that `evRd` and `evRs1` are meaningful only while `evValid` is high. They also assume that a clear may coincide with any event, and that reset is held for at least one clock edge. The stimulus drives only whole events or idle cycles at falling edges. It draws register numbers from a set that mixes both link registers with zero and ordinary registers, so that every push/pop class occurs. It deliberately overfills the stack and then pops it past empty.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef struct packed {
    logic clear;
    logic push;
    logic pop;
  } rasStrobe_t;

  localparam logic [4:0] LINK_A = 5'd1;
  localparam logic [4:0] LINK_B = 5'd5;

  function automatic logic isLinkReg(input logic [4:0] regNum);
    return (regNum == LINK_A) || (regNum == LINK_B);
  endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
(
  input  logic       clearReq,
  input  logic       evValid,
  input  logic       evIsJalr,
  input  logic [4:0] evRd,
  input  logic [4:0] evRs1,
  output rasStrobe_t strobe
);

  logic rdLink;
  logic rs1Link;
  logic sameReg;

  assign rdLink  = isLinkReg(evRd);
  assign rs1Link = isLinkReg(evRs1);
  assign sameReg = (evRd == evRs1);

  always_comb begin
    strobe = '0;
    if (clearReq) begin
      strobe.clear = 1'b1;
    end else if (evValid) begin
      strobe.push = rdLink;
      if (evIsJalr) begin
        strobe.pop = rs1Link && !(rdLink && sameReg);
      end
    end
  end

endmodule

// File: rtl/ras_dp.sv
module ras_dp
  import ras_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rasStrobe_t        strobe,
  input  logic [ADDR_W-1:0] evNextPc,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget,
  output logic              stackEmpty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] entries [DEPTH];
  logic [PTR_W-1:0]  topIdx;
  logic [CNT_W-1:0]  count;
  logic [PTR_W-1:0]  incIdx;
  logic [PTR_W-1:0]  decIdx;
  logic              hasEntry;
  logic              popEff;
  logic              wrEn;
  logic [PTR_W-1:0]  wrIdx;

  assign incIdx   = (topIdx == LAST_IDX) ? '0 : topIdx + 1'b1;
  assign decIdx   = (topIdx == '0) ? LAST_IDX : topIdx - 1'b1;
  assign hasEntry = (count != '0);
  assign popEff   = strobe.pop && hasEntry && !strobe.clear;

  assign predValid  = popEff;
  assign predTarget = popEff ? entries[topIdx] : '0;
  assign stackEmpty = !hasEntry;

  always_comb begin
    wrEn  = 1'b0;
    wrIdx = incIdx;
    if (!strobe.clear && strobe.push) begin
      wrEn  = 1'b1;
      wrIdx = popEff ? topIdx : incIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topIdx <= '0;
      count  <= '0;
    end else if (strobe.clear) begin
      topIdx <= '0;
      count  <= '0;
    end else if (strobe.push && !popEff) begin
      topIdx <= incIdx;
      if (count != FULL_CNT) count <= count + 1'b1;
    end else if (popEff && !strobe.push) begin
      topIdx <= decIdx;
      count  <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) entries[wrIdx] <= evNextPc;
  end

endmodule

// File: rtl/ras_top.sv
module ras_top
  import ras_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearReq,
  input  logic              evValid,
  input  logic              evIsJalr,
  input  logic [4:0]        evRd,
  input  logic [4:0]        evRs1,
  input  logic [ADDR_W-1:0] evNextPc,
  output logic              predValid,
  output logic [ADDR_W-1:0] predTarget,
  output logic              stackEmpty
);

  rasStrobe_t strobe;

  ras_ctrl u_ctrl (
    .clearReq (clearReq),
    .evValid  (evValid),
    .evIsJalr (evIsJalr),
    .evRd     (evRd),
    .evRs1    (evRs1),
    .strobe   (strobe)
  );

  ras_dp #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .evNextPc   (evNextPc),
    .predValid  (predValid),
    .predTarget (predTarget),
    .stackEmpty (stackEmpty)
  );

endmodule

// File: rtl/ras_chk.sv
module ras_chk
  import ras_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearReq,
  input logic              evValid,
  input logic              evIsJalr,
  input logic [4:0]        evRd,
  input logic [4:0]        evRs1,
  input logic              predValid,
  input logic [ADDR_W-1:0] predTarget,
  input logic              stackEmpty
);

  AST_DIRECT_NO_PRED: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !evIsJalr) |-> !predValid); // R2

  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !clearReq && isLinkReg(evRd)) |=> !stackEmpty); // R3

  AST_NONLINK_SRC_NO_PRED: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !isLinkReg(evRs1)) |-> !predValid); // R5

  AST_SAME_LINK_NO_PRED: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evIsJalr && isLinkReg(evRd) && evRd == evRs1) |-> !predValid); // R7

  AST_EMPTY_NO_PRED: assert property (@(posedge clk) disable iff (!rstN)
    stackEmpty |-> !predValid); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> stackEmpty); // R10

  AST_CLEAR_NO_PRED: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |-> !predValid); // R10

  AST_TARGET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !predValid |-> (predTarget == '0)); // R11

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!evValid && !clearReq) |=> $stable(stackEmpty)); // R12

endmodule

bind ras_top ras_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clearReq   (clearReq),
  .evValid    (evValid),
  .evIsJalr   (evIsJalr),
  .evRd       (evRd),
  .evRs1      (evRs1),
  .predValid  (predValid),
  .predTarget (predTarget),
  .stackEmpty (stackEmpty)
);

// File: tb/ras_top_tb.sv
module ras_top_tb;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clearReq = 1'b0;
  logic              evValid = 1'b0;
  logic              evIsJalr = 1'b0;
  logic [4:0]        evRd = '0;
  logic [4:0]        evRs1 = '0;
  logic [ADDR_W-1:0] evNextPc = '0;
  logic              predValid;
  logic [ADDR_W-1:0] predTarget;
  logic              stackEmpty;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [ADDR_W-1:0] model [$];

  always #10 clk = ~clk;

  ras_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .clearReq(clearReq), .evValid(evValid),
    .evIsJalr(evIsJalr), .evRd(evRd), .evRs1(evRs1), .evNextPc(evNextPc),
    .predValid(predValid), .predTarget(predTarget), .stackEmpty(stackEmpty)
  );

  function automatic bit isLink(input int r);
    return (r == 1) || (r == 5);
  endfunction

  task automatic check(input string tag, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, compare combinational outputs just
  // before the rising edge, then advance the reference model.
  task automatic step(input bit v, input bit j, input int rd, input int rs1,
                      input logic [ADDR_W-1:0] pc, input bit clr, input string tag);
    bit expValid;
    bit doPush;
    bit doPop;
    logic [ADDR_W-1:0] expTarget;
    @(negedge clk);
    evValid  = v;
    evIsJalr = j;
    evRd     = 5'(rd);
    evRs1    = 5'(rs1);
    evNextPc = pc;
    clearReq = clr;
    doPush = v && !clr && isLink(rd);
    doPop  = v && !clr && j && isLink(rs1) && !(isLink(rd) && rd == rs1);
    expValid  = doPop && (model.size() > 0);
    expTarget = expValid ? model[$] : '0;
    #5;
    check(tag, ADDR_W'(predValid), ADDR_W'(expValid), "predValid");
    check(tag, predTarget, expTarget, "predTarget");
    check("R11", ADDR_W'(stackEmpty), ADDR_W'(model.size() == 0), "stackEmpty");
    if (clr) model.delete();
    else if (expValid && doPush) model[model.size()-1] = pc;
    else if (expValid) void'(model.pop_back());
    else if (doPush) begin
      model.push_back(pc);
      if (model.size() > DEPTH) void'(model.pop_front());
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1, 1, 32'hDEAD0000, 1'b0, tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check("R11", ADDR_W'(stackEmpty), 1, "stackEmpty after reset");
    check("R11", ADDR_W'(predValid), 0, "predValid after reset");
    rstN = 1'b1;

    // R1 / R2: direct jumps, only x1/x5 destinations push
    step(1, 0, 2, 0, 32'h100, 0, "R1");
    step(1, 0, 0, 0, 32'h104, 0, "R1");
    step(1, 0, 1, 0, 32'h108, 0, "R2");
    step(1, 0, 5, 1, 32'h10C, 0, "R2");
    // R4 pops in order
    step(1, 1, 0, 1, 32'h0, 0, "R4");
    step(1, 1, 7, 5, 32'h0, 0, "R4");
    // R8 empty pop
    step(1, 1, 0, 5, 32'h0, 0, "R8");
    // R3 push via indirect
    step(1, 1, 1, 9, 32'h200, 0, "R3");
    // R5 neither link, R12 idle
    step(1, 1, 3, 4, 32'h204, 0, "R5");
    idle("R12");
    // R6 swap with entry, then on empty
    step(1, 1, 5, 1, 32'h300, 0, "R6");
    step(1, 1, 0, 1, 32'h0, 0, "R6");
    step(1, 1, 1, 5, 32'h304, 0, "R6");
    step(1, 1, 0, 1, 32'h0, 0, "R6");
    // R7 same link register pushes only
    step(1, 1, 5, 5, 32'h400, 0, "R7");
    step(1, 1, 1, 1, 32'h404, 0, "R7");
    step(1, 1, 0, 1, 32'h0, 0, "R7");
    step(1, 1, 0, 5, 32'h0, 0, "R7");
    // R9 overfill then drain past empty
    for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 1, 0, 32'h1000 + 32'(i*4), 0, "R9");
    for (int i = 0; i < DEPTH + 1; i++) step(1, 1, 0, 1, 32'h0, 0, "R9");
    // R10 clear with a simultaneous pop
    step(1, 0, 1, 0, 32'h500, 0, "R10");
    step(1, 0, 5, 0, 32'h504, 0, "R10");
    step(1, 1, 0, 1, 32'h0, 1, "R10");
    step(1, 1, 0, 5, 32'h0, 0, "R10");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int pick[6] = '{0, 1, 2, 5, 6, 31};
      int rd  = pick[$urandom_range(5)];
      int rs1 = pick[$urandom_range(5)];
      bit v   = ($urandom_range(9) != 0);
      bit clr = ($urandom_range(49) == 0);
      step(v, 1'($urandom_range(1)), rd, rs1, $urandom & 32'hFFFF_FFFC, clr, "R12");
    end
    idle("R12");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule